// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Protect Unit

This unit keeps the status byte of a serial EEPROM-style slave and rules on every write the slave attempts. Inside it sit a write-enable latch, a two-bit block-protect level, a protect-enable bit, and a busy indication driven by the external write sequencer. The serial front end hands it decoded strobes (latch set, latch clear, status-write request with a data byte), the chip-select level, the write-protect pin and the current target address. It returns the byte a status read would shift out, plus two permission flags: one for a memory byte write and one for a status write.

Protection works in quadrants counted from the top of the array: none, the upper quarter, the upper half, or the whole array. A second, pin-gated lock freezes the status register itself while the write-protect pin is low and protect-enable is set. A status write is staged while chip select is low and takes effect on the rising edge of chip select, which is the point where the self-timed cycle begins. The nonvolatile bits are modelled as flops that reset to zero.

Top module: `sr_protect_unit`

## Requirements
- R1: After reset the status byte reads 0x00 and both permission flags are low.
- R2: While not busy the status byte is {protect-enable, 3'b000, level[1], level[0], write-enable latch, 1'b0}, with protect-enable at bit 7, the level at bits 3..2 and the latch at bit 1.
- R3: While busy_i is high the status byte reads 0xFF and both permission flags are low.
- R4: A latch-set strobe sets the write-enable latch and a latch-clear strobe clears it, whatever the write-protect pin; when both arrive in the same cycle the clear wins.
- R5: The write-enable latch clears on the cycle busy_i falls, ending a self-timed write.
- R6: With ADDR_W = 12, level 00 protects nothing, 01 protects 0xC00..0xFFF, 10 protects 0x800..0xFFF and 11 protects all addresses; mem_wr_ok_o is high only when the latch is set, the unit is not busy and the address is unprotected.
- R7: Hardware lock is active only when wp_n_i is low and protect-enable is 1; while active, sr_wr_ok_o is low and no status write is taken, including one that would clear protect-enable. Otherwise sr_wr_ok_o equals latch-set and not busy.
- R8: A permitted status-write request made while cs_n_i is low is staged and becomes visible on the cycle cs_n_i rises; it loads only bits 7, 3 and 2 from the data byte, and bits 6..4, 1 and 0 of the data are ignored.
- R9: If the hardware lock becomes active while a status write is staged, the staged write is dropped; once the write has been committed, the pin has no further effect on it.
- R10: Only the low ADDR_W address bits take part in the protection check; bits above them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wel_set_i | input | 1 | Strobe: set the write-enable latch |
| wel_clr_i | input | 1 | Strobe: clear the write-enable latch |
| sr_wr_req_i | input | 1 | Strobe: status-write request |
| sr_wr_data_i | input | 8 | Data byte of the status write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cs_n_i | input | 1 | Chip select, active low |
| busy_i | input | 1 | Self-timed write cycle running |
| addr_i | input | ADDR_IN_W | Target memory address |
| status_o | output | 8 | Status byte for reads |
| mem_wr_ok_o | output | 1 | Memory byte write permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The hardest case to reach is a status write that has been accepted but not yet committed when the hardware lock engages: protect-enable must already be set, a request must be staged with chip select low and the pin must fall before chip select rises. The stimulus first commits protect-enable through an ordinary write, then stages a new level, pulls the pin low for one cycle with chip select still low, and shows through the status byte that the old level survives the later chip-select rise. A second sequence commits a write and drops the pin only afterwards, to show the committed value holds.

// File: rtl/sru_pkg.sv
package sru_pkg;
   typedef enum logic [1:0] {
      LVL_NONE = 2'b00,
      LVL_QTR  = 2'b01,
      LVL_HALF = 2'b10,
      LVL_ALL  = 2'b11
   } prot_lvl_e;

   typedef struct packed {
      logic      lock_en;
      prot_lvl_e lvl;
   } nv_bits_t;

   localparam int SB_LOCK = 7;
   localparam int SB_LVL1 = 3;
   localparam int SB_LVL0 = 2;
   localparam int SB_WEL  = 1;
   localparam int SB_BUSY = 0;
   localparam int SB_W    = 8;

   function automatic nv_bits_t pick_nv(input logic [SB_W-1:0] b);
      nv_bits_t r;
      r.lock_en = b[SB_LOCK];
      r.lvl     = prot_lvl_e'({b[SB_LVL1], b[SB_LVL0]});
      return r;
   endfunction
endpackage

// File: rtl/sru_wel_latch.sv
module sru_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic busy_i,
   output logic wel_o
);
   logic busy_q;
   logic busy_fall;

   assign busy_fall = busy_q & ~busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wel_o  <= 1'b0;
      end else begin
         busy_q <= busy_i;
         if (busy_fall)
            wel_o <= 1'b0;
         else if (!busy_i) begin
            if (clr_i)
               wel_o <= 1'b0;
            else if (set_i)
               wel_o <= 1'b1;
         end
      end
   end

   assert_autoclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |=> !wel_o);
   assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !busy_i) |=> !wel_o);
   assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i && !busy_i && !$fell(busy_i)) |=> wel_o);
endmodule

// File: rtl/sru_blk_prot.sv
module sru_blk_prot
   import sru_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  prot_lvl_e         lvl_i,
   output logic              hit_o
);
   localparam int TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("sru_blk_prot: ADDR_W must be at least 2");
      end
   endgenerate

   logic upper_half;
   logic upper_qtr;

   assign upper_half = addr_i[TOP];
   assign upper_qtr  = addr_i[TOP] & addr_i[TOP-1];

   always_comb begin
      unique case (lvl_i)
         LVL_NONE: hit_o = 1'b0;
         LVL_QTR:  hit_o = upper_qtr;
         LVL_HALF: hit_o = upper_half;
         default:  hit_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/sru_stat_reg.sv
module sru_stat_reg
   import sru_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic [SB_W-1:0] data_i,
   input  logic            ok_i,
   input  logic            lock_i,
   input  logic            cs_n_i,
   output nv_bits_t        nv_o
);
   nv_bits_t pend_q;
   logic     pend_vld;
   logic     cs_n_q;
   logic     cs_rise;

   assign cs_rise = ~cs_n_q & cs_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_o     <= '0;
         pend_q   <= '0;
         pend_vld <= 1'b0;
         cs_n_q   <= 1'b1;
      end else begin
         cs_n_q <= cs_n_i;
         if (pend_vld && lock_i)
            pend_vld <= 1'b0;
         else if (pend_vld && cs_rise) begin
            nv_o     <= pend_q;
            pend_vld <= 1'b0;
         end else if (req_i && ok_i && !cs_n_i) begin
            pend_q   <= pick_nv(data_i);
            pend_vld <= 1'b1;
         end
      end
   end

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(nv_o));
   assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vld && lock_i) |=> !pend_vld);
   assert_only_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_vld |=> $stable(nv_o));
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
   import sru_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int ADDR_IN_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wel_set_i,
   input  logic                 wel_clr_i,
   input  logic                 sr_wr_req_i,
   input  logic [7:0]           sr_wr_data_i,
   input  logic                 wp_n_i,
   input  logic                 cs_n_i,
   input  logic                 busy_i,
   input  logic [ADDR_IN_W-1:0] addr_i,
   output logic [7:0]           status_o,
   output logic                 mem_wr_ok_o,
   output logic                 sr_wr_ok_o
);
   generate
      if (ADDR_IN_W < ADDR_W) begin : g_bad_addr
         $error("sr_protect_unit: ADDR_IN_W must not be below ADDR_W");
      end
   endgenerate

   logic     wel;
   logic     hw_lock;
   logic     blk_hit;
   nv_bits_t nv;

   sru_wel_latch u_wel (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wel_set_i),
      .clr_i  (wel_clr_i),
      .busy_i (busy_i),
      .wel_o  (wel)
   );

   assign hw_lock    = ~wp_n_i & nv.lock_en;
   assign sr_wr_ok_o = wel & ~busy_i & ~hw_lock;

   sru_stat_reg u_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (sr_wr_req_i),
      .data_i (sr_wr_data_i),
      .ok_i   (sr_wr_ok_o),
      .lock_i (hw_lock),
      .cs_n_i (cs_n_i),
      .nv_o   (nv)
   );

   sru_blk_prot #(.ADDR_W(ADDR_W)) u_bp (
      .addr_i (addr_i[ADDR_W-1:0]),
      .lvl_i  (nv.lvl),
      .hit_o  (blk_hit)
   );

   assign mem_wr_ok_o = wel & ~busy_i & ~blk_hit;

   always_comb begin
      status_o          = '0;
      status_o[SB_LOCK] = nv.lock_en;
      status_o[SB_LVL1] = nv.lvl[1];
      status_o[SB_LVL0] = nv.lvl[0];
      status_o[SB_WEL]  = wel;
      if (busy_i)
         status_o = '1;
   end

   assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (!mem_wr_ok_o && !sr_wr_ok_o));
   assert_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && status_o[3:2] == 2'b11) |-> !mem_wr_ok_o);
   assert_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_ok_o |-> status_o[1]);
   assert_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_req_i && (sr_wr_data_i[6:4] != 3'b000 || sr_wr_data_i[1:0] != 2'b00))
      |=> (busy_i || status_o[6:4] == 3'b000));
   assert_hiaddr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(addr_i[ADDR_W-1:0]) && !$stable(addr_i) && $stable(status_o)
       && !busy_i && !$past(busy_i))
      |-> mem_wr_ok_o == $past(mem_wr_ok_o));
endmodule

// File: tb/sr_protect_unit_tb.sv
module sr_protect_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wel_set_i = 1'b0;
   logic        wel_clr_i = 1'b0;
   logic        sr_wr_req_i = 1'b0;
   logic [7:0]  sr_wr_data_i = '0;
   logic        wp_n_i = 1'b1;
   logic        cs_n_i = 1'b1;
   logic        busy_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic [7:0]  status_o;
   logic        mem_wr_ok_o;
   logic        sr_wr_ok_o;

   typedef struct {
      logic [7:0] st;
      logic       m;
      logic       s;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 0;

   always #5 clk = ~clk;

   sr_protect_unit #(.ADDR_W(12), .ADDR_IN_W(16)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wel_set_i    (wel_set_i),
      .wel_clr_i    (wel_clr_i),
      .sr_wr_req_i  (sr_wr_req_i),
      .sr_wr_data_i (sr_wr_data_i),
      .wp_n_i       (wp_n_i),
      .cs_n_i       (cs_n_i),
      .busy_i       (busy_i),
      .addr_i       (addr_i),
      .status_o     (status_o),
      .mem_wr_ok_o  (mem_wr_ok_o),
      .sr_wr_ok_o   (sr_wr_ok_o)
   );

   // Monitor: compares outputs 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (status_o !== e.st || mem_wr_ok_o !== e.m || sr_wr_ok_o !== e.s) begin
               n_bad++;
               $display("FAIL %s: status=%02h mem_ok=%0b sr_ok=%0b expected status=%02h mem_ok=%0b sr_ok=%0b",
                        e.tag, status_o, mem_wr_ok_o, sr_wr_ok_o, e.st, e.m, e.s);
            end
         end
      end
   end

   // Driver: one cycle of stimulus, expected outputs after the edge
   task automatic step(input logic set, input logic clr, input logic req,
                       input logic [7:0] data, input logic wpn, input logic csn,
                       input logic busy, input logic [15:0] addr,
                       input logic [7:0] est, input logic em, input logic es,
                       input string tag);
      exp_t e;
      @(negedge clk);
      wel_set_i    = set;
      wel_clr_i    = clr;
      sr_wr_req_i  = req;
      sr_wr_data_i = data;
      wp_n_i       = wpn;
      cs_n_i       = csn;
      busy_i       = busy;
      addr_i       = addr;
      @(posedge clk);
      e.st = est; e.m = em; e.s = es; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      //   set clr req data   wpn csn bsy addr      status m s   tag
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h00, 0, 0, "R1 reset state");
      step(1, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h02, 1, 1, "R4 latch set");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0FFF, 8'h02, 1, 1, "R6 level none top address");
      step(0, 0, 1, 8'hFC, 1, 0, 0, 16'h0000, 8'h02, 1, 1, "R8 staged not visible");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h8E, 0, 1, "R8 commit on cs rise, reserved data ignored");
      step(0, 0, 0, 8'h00, 0, 1, 0, 16'h0000, 8'h8E, 0, 0, "R7 lock active");
      step(0, 0, 1, 8'h00, 0, 0, 0, 16'h0000, 8'h8E, 0, 0, "R7 clear attempt refused");
      step(0, 0, 0, 8'h00, 0, 1, 0, 16'h0000, 8'h8E, 0, 0, "R7 lock enable kept");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h8E, 0, 1, "R7 pin high releases lock");
      step(0, 0, 1, 8'h84, 1, 0, 0, 16'h0000, 8'h8E, 0, 1, "R9 stage level 01");
      step(0, 0, 0, 8'h00, 0, 0, 0, 16'h0000, 8'h8E, 0, 0, "R9 pin falls with cs low");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h8E, 0, 1, "R9 cancelled write not committed");
      step(0, 0, 1, 8'h07, 1, 0, 0, 16'h0000, 8'h8E, 0, 1, "R8 stage level 01 lock off");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0BFF, 8'h06, 1, 1, "R8 commit, read-only bits untouched");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0C00, 8'h06, 0, 1, "R6 quarter boundary");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'hF7FF, 8'h06, 1, 1, "R10 upper bits ignored, unprotected");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h3FFF, 8'h06, 0, 1, "R10 upper bits ignored, protected");
      step(0, 0, 0, 8'h00, 0, 1, 0, 16'h0000, 8'h06, 1, 1, "R7 pin low without lock enable");
      step(0, 0, 1, 8'h08, 1, 0, 0, 16'h0000, 8'h06, 1, 1, "R8 stage level 10");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h07FF, 8'h0A, 1, 1, "R6 half below boundary");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0800, 8'h0A, 0, 1, "R6 half boundary");
      step(0, 0, 1, 8'h88, 1, 0, 0, 16'h0800, 8'h0A, 0, 1, "R8 stage lock enable");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0800, 8'h8A, 0, 1, "R8 commit lock enable");
      step(0, 0, 0, 8'h00, 0, 1, 0, 16'h0800, 8'h8A, 0, 0, "R9 pin after commit no effect");
      step(0, 0, 0, 8'h00, 1, 1, 1, 16'h0000, 8'hFF, 0, 0, "R3 busy image");
      step(1, 0, 0, 8'h00, 1, 1, 1, 16'h0000, 8'hFF, 0, 0, "R3 busy flags low");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0800, 8'h88, 0, 0, "R5 latch cleared at end of cycle");
      step(1, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h8A, 1, 1, "R4 set again, R2 layout");
      step(0, 1, 0, 8'h00, 0, 1, 0, 16'h0000, 8'h88, 0, 0, "R4 clear with pin low");
      step(1, 1, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h88, 0, 0, "R4 clear wins over set");
      step(1, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h8A, 1, 1, "R4 set");
      step(0, 0, 1, 8'h0C, 1, 0, 0, 16'h0000, 8'h8A, 1, 1, "R8 stage level 11");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0123, 8'h0E, 0, 1, "R6 whole array protected");
      step(0, 0, 0, 8'h00, 1, 1, 0, 16'h0000, 8'h0E, 0, 1, "R6 whole array low address");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule